// File: doc/BRIEF.md
# External SRAM Multiplexed Bus Interface

This block sits between the 8-bit data-memory port of a CPU and an external static RAM. A single set of eight pins carries the low address byte and then the data byte. A second group of pins carries the upper address byte. A dedicated latch-enable pin tells an external latch when to capture the low address. Two active-low strobes, one for read and one for write, frame the data phase. A two-bit control register turns the interface on and selects whether each access is stretched by one wait cycle.

While the interface is on, it owns the shared pins, the upper address pins and both strobe pins. It ignores the port value and direction settings for those pins. While it is off, every one of those pins reflects the ordinary port value and direction inputs. The CPU side is a valid/ready request channel. `req_ready` is high only while no access is running, and a request transfers on a cycle where both `req_valid` and `req_ready` are high. A request that transfers while the interface is off is consumed and dropped. `stall` is high for every cycle of a running access, so the CPU can freeze its pipeline. Read data returns as a single-cycle `rsp_valid` pulse with no back-pressure: the CPU must take it in that cycle.

Top module: `xmem_bus_if`

## Requirements
- R1: After reset, `ctl_rdata` reads 0 (interface off, no wait cycle), `stall` is 0, `req_ready` is 1 and `ale_pin_o` is 0.
- R2: While the interface is off and idle, each pin output and output-enable follows the matching port value and port direction input: shared, upper and strobe groups.
- R3: While the interface is on, the upper address pins and both strobe pins are driven (enable all ones) whatever the port direction inputs say. The upper pins carry address bits 15:8 of the current or most recent access, and each strobe idles at 1. `ctl_wdata` bit 1 is the enable and bit 0 is the wait select, and a write through `ctl_we` takes effect at the next clock edge.
- R4: In the first cycle of an access, `ale_pin_o` is 1 for exactly that cycle, and the shared pins drive address bits 7:0 with all output-enables set.
- R5: In every cycle of a write access after the first, the shared pins drive the write data, the write strobe (`strb_pin_o` bit 1) is 0 and the read strobe (bit 0) is 1.
- R6: In every cycle of a read access after the first, the shared pins are released (enable all zeros), the read strobe is 0 and the write strobe is 1. The byte on `lo_pin_i` in the final strobe cycle is returned on `rsp_rdata` with `rsp_valid` high for one cycle, in the cycle right after the access. Writes never pulse `rsp_valid`.
- R7: With the wait select at 0, `stall` is high for exactly 3 cycles per access and the strobe is low for the last 2 of them.
- R8: With the wait select at 1, `stall` is high for exactly 4 cycles per access and the strobe is low for the last 3 of them.
- R9: A request that transfers while the interface is off has no effect. It causes no latch-enable pulse, no strobe, no stall and no response.
- R10: `req_ready` is 0 while `stall` is 1. A request held during an access is accepted only after that access ends. The address, direction, data and wait select in effect at the transfer govern the whole access.
- R11: If the interface is turned off during an access, the access runs to its end with the interface still owning the pins. The pins return to port control in the first idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 2 | Control write value: bit 1 enable, bit 0 wait select |
| ctl_rdata | output | 2 | Control register contents |
| req_valid | input | 1 | CPU request valid |
| req_ready | output | 1 | Interface idle, request may transfer |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid for one cycle |
| rsp_rdata | output | DATA_W | Read data |
| stall | output | 1 | Access running, CPU must wait |
| lo_port_val | input | DATA_W | Port value for shared pins |
| lo_port_dir | input | DATA_W | Port direction for shared pins (1 = drive) |
| hi_port_val | input | ADDR_W-DATA_W | Port value for upper address pins |
| hi_port_dir | input | ADDR_W-DATA_W | Port direction for upper address pins |
| strb_port_val | input | 2 | Port value for strobe pins (bit 0 read, bit 1 write) |
| strb_port_dir | input | 2 | Port direction for strobe pins |
| lo_pin_i | input | DATA_W | Shared pin input |
| lo_pin_o | output | DATA_W | Shared pin output |
| lo_pin_oe | output | DATA_W | Shared pin output enable |
| hi_pin_o | output | ADDR_W-DATA_W | Upper address pin output |
| hi_pin_oe | output | ADDR_W-DATA_W | Upper address pin output enable |
| strb_pin_o | output | 2 | Strobe pin output, active low (bit 0 read, bit 1 write) |
| strb_pin_oe | output | 2 | Strobe pin output enable |
| ale_pin_o | output | 1 | Address latch enable |

## Verification
The bench builds the block with its default widths: a 16-bit address split into an 8-bit shared byte and an 8-bit upper byte. With these widths every pin group can be compared against a byte pattern that differs between the address, data, port value and port direction. A wrong mux leg or a swapped byte therefore shows up as a miscompare. Access lengths of three and four cycles are both run, with read and write accesses. The shared-pin input is changed between strobe cycles, so a sample taken in the wrong cycle returns a visibly different byte.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  typedef enum logic [2:0] {
    XS_IDLE = 3'd0,
    XS_ADDR = 3'd1,
    XS_STRB = 3'd2,
    XS_WAIT = 3'd3,
    XS_LAST = 3'd4
  } xs_state_e;

  localparam int CTL_W      = 2;
  localparam int CTL_EN_BIT = 1;
  localparam int CTL_WS_BIT = 0;
  localparam int STRB_RD    = 0;
  localparam int STRB_WR    = 1;
endpackage

// File: rtl/xmem_ctrl_reg.sv
module xmem_ctrl_reg
  import xmem_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  output logic [CTL_W-1:0] rdata,
  output logic             en,
  output logic             ws
);
  logic [CTL_W-1:0] ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ctl_q <= '0;
    else if (we) ctl_q <= wdata;
  end

  assign rdata = ctl_q;
  assign en    = ctl_q[CTL_EN_BIT];
  assign ws    = ctl_q[CTL_WS_BIT];
endmodule

// File: rtl/xmem_seq.sv
module xmem_seq
  import xmem_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              ws,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] lo_pin_i,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              busy,
  output logic              ph_addr,
  output logic              ph_strb,
  output logic              wr_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q
);
  xs_state_e state_q, state_d;
  logic      ws_q;
  logic      start;

  assign req_ready = (state_q == XS_IDLE);
  assign start     = req_valid && req_ready && en;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      XS_IDLE: if (start) state_d = XS_ADDR;
      XS_ADDR: state_d = XS_STRB;
      XS_STRB: state_d = ws_q ? XS_WAIT : XS_LAST;
      XS_WAIT: state_d = XS_LAST;
      XS_LAST: state_d = XS_IDLE;
      default: state_d = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= XS_IDLE;
      ws_q    <= 1'b0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (start) begin
        ws_q    <= ws;
        wr_q    <= req_we;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= (state_q == XS_LAST) && !wr_q;
      if ((state_q == XS_LAST) && !wr_q) rsp_rdata <= lo_pin_i;
    end
  end

  assign busy    = (state_q != XS_IDLE);
  assign ph_addr = (state_q == XS_ADDR);
  assign ph_strb = (state_q == XS_STRB) || (state_q == XS_WAIT) || (state_q == XS_LAST);
endmodule

// File: rtl/xmem_pin_mux.sv
module xmem_pin_mux
  import xmem_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     own,
  input  logic                     ph_addr,
  input  logic                     ph_strb,
  input  logic                     wr_q,
  input  logic [ADDR_W-1:0]        addr_q,
  input  logic [DATA_W-1:0]        wdata_q,
  input  logic [DATA_W-1:0]        lo_port_val,
  input  logic [DATA_W-1:0]        lo_port_dir,
  input  logic [ADDR_W-DATA_W-1:0] hi_port_val,
  input  logic [ADDR_W-DATA_W-1:0] hi_port_dir,
  input  logic [1:0]               strb_port_val,
  input  logic [1:0]               strb_port_dir,
  output logic [DATA_W-1:0]        lo_pin_o,
  output logic [DATA_W-1:0]        lo_pin_oe,
  output logic [ADDR_W-DATA_W-1:0] hi_pin_o,
  output logic [ADDR_W-DATA_W-1:0] hi_pin_oe,
  output logic [1:0]               strb_pin_o,
  output logic [1:0]               strb_pin_oe,
  output logic                     ale_pin_o
);
  localparam int HI_W = ADDR_W - DATA_W;

  logic lo_drive;
  logic rd_act;
  logic wr_act;

  assign lo_drive = ph_addr || (ph_strb && wr_q);
  assign rd_act   = ph_strb && !wr_q;
  assign wr_act   = ph_strb && wr_q;

  for (genvar b = 0; b < DATA_W; b++) begin : g_lo
    always_comb begin
      if (own) begin
        lo_pin_o[b]  = ph_addr ? addr_q[b] : wdata_q[b];
        lo_pin_oe[b] = lo_drive;
      end else begin
        lo_pin_o[b]  = lo_port_val[b];
        lo_pin_oe[b] = lo_port_dir[b];
      end
    end
  end

  for (genvar b = 0; b < HI_W; b++) begin : g_hi
    assign hi_pin_o[b]  = own ? addr_q[DATA_W+b] : hi_port_val[b];
    assign hi_pin_oe[b] = own ? 1'b1 : hi_port_dir[b];
  end

  always_comb begin
    if (own) begin
      strb_pin_o[STRB_RD] = !rd_act;
      strb_pin_o[STRB_WR] = !wr_act;
      strb_pin_oe         = 2'b11;
    end else begin
      strb_pin_o          = strb_port_val;
      strb_pin_oe         = strb_port_dir;
    end
  end

  assign ale_pin_o = ph_addr;
endmodule

// File: rtl/xmem_bus_if.sv
module xmem_bus_if
  import xmem_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ctl_we,
  input  logic [1:0]               ctl_wdata,
  output logic [1:0]               ctl_rdata,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_we,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     rsp_valid,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic                     stall,
  input  logic [DATA_W-1:0]        lo_port_val,
  input  logic [DATA_W-1:0]        lo_port_dir,
  input  logic [ADDR_W-DATA_W-1:0] hi_port_val,
  input  logic [ADDR_W-DATA_W-1:0] hi_port_dir,
  input  logic [1:0]               strb_port_val,
  input  logic [1:0]               strb_port_dir,
  input  logic [DATA_W-1:0]        lo_pin_i,
  output logic [DATA_W-1:0]        lo_pin_o,
  output logic [DATA_W-1:0]        lo_pin_oe,
  output logic [ADDR_W-DATA_W-1:0] hi_pin_o,
  output logic [ADDR_W-DATA_W-1:0] hi_pin_oe,
  output logic [1:0]               strb_pin_o,
  output logic [1:0]               strb_pin_oe,
  output logic                     ale_pin_o
);
  logic              en, ws, busy;
  logic              ph_addr, ph_strb, wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  xmem_ctrl_reg u_ctl (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ctl_we),
    .wdata (ctl_wdata),
    .rdata (ctl_rdata),
    .en    (en),
    .ws    (ws)
  );

  xmem_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .ws        (ws),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_we    (req_we),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .lo_pin_i  (lo_pin_i),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .busy      (busy),
    .ph_addr   (ph_addr),
    .ph_strb   (ph_strb),
    .wr_q      (wr_q),
    .addr_q    (addr_q),
    .wdata_q   (wdata_q)
  );

  xmem_pin_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
    .own           (en || busy),
    .ph_addr       (ph_addr),
    .ph_strb       (ph_strb),
    .wr_q          (wr_q),
    .addr_q        (addr_q),
    .wdata_q       (wdata_q),
    .lo_port_val   (lo_port_val),
    .lo_port_dir   (lo_port_dir),
    .hi_port_val   (hi_port_val),
    .hi_port_dir   (hi_port_dir),
    .strb_port_val (strb_port_val),
    .strb_port_dir (strb_port_dir),
    .lo_pin_o      (lo_pin_o),
    .lo_pin_oe     (lo_pin_oe),
    .hi_pin_o      (hi_pin_o),
    .hi_pin_oe     (hi_pin_oe),
    .strb_pin_o    (strb_pin_o),
    .strb_pin_oe   (strb_pin_oe),
    .ale_pin_o     (ale_pin_o)
  );

  assign stall = busy;
endmodule

// File: rtl/xmem_bus_chk.sv
module xmem_bus_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        ctl_rdata,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              stall,
  input logic [DATA_W-1:0] lo_pin_oe,
  input logic [DATA_W-1:0] lo_port_dir,
  input logic [1:0]        strb_pin_o,
  input logic              ale_pin_o
);
  logic [2:0] run_cnt;
  logic       ws_cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
      ws_cap  <= 1'b0;
    end else begin
      run_cnt <= stall ? run_cnt + 3'd1 : 3'd0;
      if (req_valid && req_ready && ctl_rdata[1]) ws_cap <= ctl_rdata[0];
    end
  end

  p_ale_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ale_pin_o |=> !ale_pin_o);

  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (strb_pin_o != 2'b00));

  p_read_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !strb_pin_o[0]) |-> (lo_pin_oe == '0));

  p_rsp_timing_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!stall && $past(stall)));

  p_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(stall) && !ws_cap) |-> (run_cnt == 3'd3));

  p_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(stall) && ws_cap) |-> (run_cnt == 3'd4));

  p_ready_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !req_ready);

  p_port_ctl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !ctl_rdata[1]) |-> (lo_pin_oe == lo_port_dir));

  p_no_act_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !ctl_rdata[1] && req_valid) |=> !ale_pin_o);
endmodule

bind xmem_bus_if xmem_bus_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_xmem_bus_if.sv
module test_xmem_bus_if;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int HI_W   = ADDR_W - DATA_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ctl_we = 1'b0;
  logic [1:0]        ctl_wdata = '0;
  logic [1:0]        ctl_rdata;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_we = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              rsp_valid;
  logic [DATA_W-1:0] rsp_rdata;
  logic              stall;
  logic [DATA_W-1:0] lo_port_val = 8'hA5;
  logic [DATA_W-1:0] lo_port_dir = 8'h3C;
  logic [HI_W-1:0]   hi_port_val = 8'h96;
  logic [HI_W-1:0]   hi_port_dir = 8'h0F;
  logic [1:0]        strb_port_val = 2'b01;
  logic [1:0]        strb_port_dir = 2'b10;
  logic [DATA_W-1:0] lo_pin_i = '0;
  logic [DATA_W-1:0] lo_pin_o, lo_pin_oe;
  logic [HI_W-1:0]   hi_pin_o, hi_pin_oe;
  logic [1:0]        strb_pin_o, strb_pin_oe;
  logic              ale_pin_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  xmem_bus_if #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_xmem_bus_if (.*);

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_ctl(input logic en, input logic ws);
    ctl_we    = 1'b1;
    ctl_wdata = {en, ws};
    tick();
    ctl_we    = 1'b0;
    chk("R3", "ctl_rdata", 32'(ctl_rdata), 32'({en, ws}));
  endtask

  task automatic chk_port_ctl(input string req);
    chk(req, "lo_o",   32'(lo_pin_o),    32'(lo_port_val));
    chk(req, "lo_oe",  32'(lo_pin_oe),   32'(lo_port_dir));
    chk(req, "hi_o",   32'(hi_pin_o),    32'(hi_port_val));
    chk(req, "hi_oe",  32'(hi_pin_oe),   32'(hi_port_dir));
    chk(req, "st_o",   32'(strb_pin_o),  32'(strb_port_val));
    chk(req, "st_oe",  32'(strb_pin_oe), 32'(strb_port_dir));
  endtask

  // One complete access; interface must already be on with wait select ws.
  task automatic do_access(input logic we, input logic [ADDR_W-1:0] addr,
                           input logic [DATA_W-1:0] wd, input logic ws,
                           input logic [DATA_W-1:0] rd_exp);
    int nstrb = ws ? 3 : 2;
    string lreq = ws ? "R8" : "R7";
    req_valid = 1'b1; req_we = we; req_addr = addr; req_wdata = wd;
    tick();
    req_valid = 1'b0;
    chk("R4", "ale", 32'(ale_pin_o), 32'd1);
    chk("R4", "lo_o addr", 32'(lo_pin_o), 32'(addr[DATA_W-1:0]));
    chk("R4", "lo_oe", 32'(lo_pin_oe), 32'hFF);
    chk("R3", "hi_o", 32'(hi_pin_o), 32'(addr[ADDR_W-1:DATA_W]));
    chk("R3", "hi_oe", 32'(hi_pin_oe), 32'hFF);
    chk("R10", "ready in access", 32'(req_ready), 32'd0);
    chk(lreq, "stall first", 32'(stall), 32'd1);
    for (int k = 0; k < nstrb; k++) begin
      if (!we) lo_pin_i = (k == nstrb - 1) ? rd_exp : ~rd_exp;
      tick();
      chk("R4", "ale low", 32'(ale_pin_o), 32'd0);
      chk(lreq, "stall", 32'(stall), 32'd1);
      if (we) begin
        chk("R5", "lo_o data", 32'(lo_pin_o), 32'(wd));
        chk("R5", "lo_oe", 32'(lo_pin_oe), 32'hFF);
        chk("R5", "strobes", 32'(strb_pin_o), 32'b01);
      end else begin
        chk("R6", "lo_oe", 32'(lo_pin_oe), 32'h00);
        chk("R6", "strobes", 32'(strb_pin_o), 32'b10);
      end
    end
    tick();
    chk(lreq, "stall end", 32'(stall), 32'd0);
    chk(lreq, "strobes idle", 32'(strb_pin_o), 32'b11);
    chk("R6", "rsp_valid", 32'(rsp_valid), 32'(!we));
    if (!we) chk("R6", "rsp_rdata", 32'(rsp_rdata), 32'(rd_exp));
    tick();
    chk("R6", "rsp one cycle", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_reset();
    chk("R1", "ctl", 32'(ctl_rdata), 32'd0);
    chk("R1", "stall", 32'(stall), 32'd0);
    chk("R1", "ready", 32'(req_ready), 32'd1);
    chk("R1", "ale", 32'(ale_pin_o), 32'd0);
    chk_port_ctl("R1");
  endtask

  task automatic t_port_follow();
    lo_port_val = 8'h5A; lo_port_dir = 8'hC3;
    hi_port_val = 8'h69; hi_port_dir = 8'hF0;
    strb_port_val = 2'b10; strb_port_dir = 2'b01;
    #1;
    chk_port_ctl("R2");
  endtask

  task automatic t_off_request();
    req_valid = 1'b1; req_we = 1'b0; req_addr = 16'h1234;
    tick();
    req_valid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      chk("R9", "ale", 32'(ale_pin_o), 32'd0);
      chk("R9", "stall", 32'(stall), 32'd0);
      chk("R9", "rsp", 32'(rsp_valid), 32'd0);
      chk("R9", "strobes", 32'(strb_pin_o), 32'(strb_port_val));
      tick();
    end
  endtask

  task automatic t_on_idle();
    set_ctl(1'b1, 1'b0);
    chk("R3", "hi_oe idle", 32'(hi_pin_oe), 32'hFF);
    chk("R3", "st_oe idle", 32'(strb_pin_oe), 32'b11);
    chk("R3", "st_o idle", 32'(strb_pin_o), 32'b11);
  endtask

  task automatic t_held_request();
    // first access write, second request held during it
    req_valid = 1'b1; req_we = 1'b1; req_addr = 16'hBEEF; req_wdata = 8'h42;
    tick();
    req_addr = 16'hCAFE; req_we = 1'b0;   // held, new contents
    chk("R10", "first addr", 32'(lo_pin_o), 32'hEF);
    tick();
    chk("R10", "data kept", 32'(lo_pin_o), 32'h42);
    chk("R10", "ready low", 32'(req_ready), 32'd0);
    chk("R10", "wr strobe kept", 32'(strb_pin_o), 32'b01);
    tick();
    tick();
    chk("R10", "idle between", 32'(stall), 32'd0);
    chk("R10", "ready", 32'(req_ready), 32'd1);
    tick();
    req_valid = 1'b0;
    chk("R10", "second ale", 32'(ale_pin_o), 32'd1);
    chk("R10", "second addr lo", 32'(lo_pin_o), 32'hFE);
    chk("R10", "second addr hi", 32'(hi_pin_o), 32'hCA);
    repeat (4) tick();
    chk("R10", "done", 32'(stall), 32'd0);
  endtask

  task automatic t_off_mid();
    set_ctl(1'b1, 1'b1);
    req_valid = 1'b1; req_we = 1'b1; req_addr = 16'h7711; req_wdata = 8'h3E;
    tick();
    req_valid = 1'b0;
    ctl_we = 1'b1; ctl_wdata = 2'b00;
    tick();
    ctl_we = 1'b0;
    chk("R11", "ctl off", 32'(ctl_rdata), 32'd0);
    chk("R11", "wr strobe", 32'(strb_pin_o), 32'b01);
    chk("R11", "st_oe", 32'(strb_pin_oe), 32'b11);
    chk("R11", "lo_o", 32'(lo_pin_o), 32'h3E);
    chk("R11", "lo_oe", 32'(lo_pin_oe), 32'hFF);
    tick();
    chk("R11", "still owned", 32'(hi_pin_oe), 32'hFF);
    tick();
    chk("R11", "last", 32'(strb_pin_o), 32'b01);
    tick();
    chk("R11", "stall end", 32'(stall), 32'd0);
    chk_port_ctl("R11");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_port_follow();
    t_off_request();
    t_on_idle();
    do_access(1'b1, 16'h12C4, 8'h9D, 1'b0, 8'h00);
    do_access(1'b0, 16'hA37B, 8'h00, 1'b0, 8'h6C);
    set_ctl(1'b1, 1'b1);
    do_access(1'b1, 16'h0F81, 8'hE2, 1'b1, 8'h00);
    do_access(1'b0, 16'hFFFE, 8'h00, 1'b1, 8'hB1);
    set_ctl(1'b1, 1'b0);
    t_held_request();
    t_off_mid();
    t_off_request();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule